// File: doc/BRIEF.md
# Reverse Directory Entry Writer

This block turns a cache-fill notification into one write into a reverse directory. The directory records which first-level cache line, in which core and which way, holds a copy of a line of the shared lower-level cache. A request carries a 40-bit physical line address, the lower-level cache way that holds the line, the requesting core, the first-level way and the address bit-4 value of the sub-block being tracked. From these the block selects one physical directory bank, a row, one of four panels and one of 64 entries, and it assembles the 16-bit word to store there.

The lower-level cache can run with all eight banks active or with only four or two, and the address bits that pick the bank and the set index move with that choice. A 4-bit mask enables physical banks two at a time. The number of set bits selects the interleave mode, and the positions of those bits say which physical pairs hold the logical banks. A mask with an illegal number of set bits makes the block raise a fault pulse in place of a write.

The outputs are registered. A request accepted on one clock edge shows up as a single-cycle write strobe, or as a fault pulse, after that edge.

Top module: `rdw_entry_writer`

## Requirements
- R1: While reset is asserted, and until the first request after it, `wr_en`, `cfg_fault` and all write fields read zero.
- R2: Each cycle with `req_valid` high produces exactly one of `wr_en` or `cfg_fault`, high for the single following cycle. A cycle with `req_valid` low produces neither in the following cycle, whatever the mask holds.
- R3: The number of set bits in `bank_mask` selects the mode: four set bits give 8 banks, two give 4 banks and one gives 2 banks. Zero or three set bits raise `cfg_fault` and suppress the write.
- R4: In 8-bank mode the bank is addr[8:6] and the 9-bit set index is addr[17:9].
- R5: In 4-bank mode the logical bank L is addr[7:6] and the index is addr[16:8]. The physical bank is 2*P + L[0], where P is the position of the lowest set mask bit when L < 2 and of the next set mask bit when L >= 2.
- R6: In 2-bank mode the logical bank is addr[6] and the index is addr[15:7]. The physical bank is twice the position of the only set mask bit, plus addr[6].
- R7: `wr_entry` is {addr4, core[2:0], l1_way[1:0]}, with addr4 in bit 5.
- R8: `wr_row` is addr[5]. `wr_panel` is one-hot, with bit n set when addr[10:9] equals n.
- R9: `wr_data` bit 15 is 1 (valid), bit 14 is the parity, bit 13 is addr4, and bits [12:0] hold the tag {index[8:0], lower_way[3:0]} with the lower-level way in bits [3:0].
- R10: The parity bit is the XOR of the 13 tag bits and addr4, so `wr_data[14:0]` always has an even number of ones.
- R11: Address bits [4:0] and bits above the widest index window have no effect on any output. The line is treated as 64-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 40 | Physical address of the filled line |
| req_lway | input | 4 | Lower-level cache way holding the line |
| req_core | input | 3 | Core whose first-level cache took the line |
| req_l1way | input | 2 | First-level cache way |
| req_a4 | input | 1 | Address bit 4 of the tracked sub-block |
| bank_mask | input | 4 | Bank-pair enable mask; bit k enables physical banks 2k and 2k+1 |
| wr_en | output | 1 | One-cycle directory write strobe |
| wr_bank | output | 3 | Physical directory bank |
| wr_row | output | 1 | Directory row |
| wr_panel | output | 4 | One-hot panel select |
| wr_entry | output | 6 | Entry index within the panel |
| wr_data | output | 16 | Entry word: valid, parity, addr4, tag |
| cfg_fault | output | 1 | One-cycle pulse: request seen with an illegal mask |

## Verification
The bench targets the 4-bank mode with a logical bank of 2 or 3 on a mask whose set bits are not adjacent. A design that always took the lowest set bit would write the wrong physical pair there. It also uses the same address under different masks, so a design that did not shift the index window would store a tag drawn from the wrong bits. Masks with zero or three set bits must give a fault and no strobe, since a design that fell back to some default mode would corrupt a live bank. Tags are chosen with both odd and even weight, with addr4 both set and clear, and the low address bits are perturbed, so a parity that dropped addr4 or an index that took in offset bits would show up in the stored word.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

  // Number of ones in a vector of up to 32 bits.
  function automatic int unsigned pop_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += {31'd0, v[i]};
    return n;
  endfunction

  // Bit position of the n-th (0-based) set bit; 0 when there is none.
  function automatic int unsigned nth_set_pos(input logic [31:0] v, input int unsigned n);
    int unsigned seen;
    int unsigned pos;
    seen = 0;
    pos  = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) begin
        if (seen == n) pos = unsigned'(i);
        seen++;
      end
    end
    return pos;
  endfunction

  function automatic logic is_pow2(input int unsigned c);
    return (c != 0) && ((c & (c - 1)) == 0);
  endfunction

  function automatic int unsigned log2_floor(input int unsigned c);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) if (c >> i != 0) r = unsigned'(i);
    return r;
  endfunction

endpackage

// File: rtl/rdw_mode_decode.sv
module rdw_mode_decode #(
  parameter int PAIRS   = 4,
  parameter int SHIFT_W = 2
) (
  input  logic [PAIRS-1:0]   mask,
  output logic               mode_ok,
  output logic [SHIFT_W-1:0] bank_bits
);
  import rdw_pkg::*;

  int unsigned pair_cnt;

  always_comb begin
    pair_cnt  = pop_count(32'(mask));
    // Legal counts are powers of two; active banks = 2 * pair_cnt.
    mode_ok   = is_pow2(pair_cnt) && (pair_cnt <= PAIRS);
    bank_bits = SHIFT_W'(log2_floor(pair_cnt) + 1);
  end
endmodule

// File: rtl/rdw_bank_map.sv
module rdw_bank_map #(
  parameter int PAIRS   = 4,
  parameter int BANK_W  = 3,
  parameter int SHIFT_W = 2,
  parameter int IDX_W   = 9,
  localparam int WIN_W  = BANK_W + IDX_W
) (
  input  logic [WIN_W-1:0]   win,        // address bits starting at the line boundary
  input  logic [PAIRS-1:0]   mask,
  input  logic [SHIFT_W-1:0] bank_bits,
  output logic [BANK_W-1:0]  phys_bank,
  output logic [IDX_W-1:0]   set_index
);
  import rdw_pkg::*;

  logic [BANK_W-1:0] lb_cand [1:BANK_W];
  logic [IDX_W-1:0]  ix_cand [1:BANK_W];

  // One candidate per interleave width: m bank bits, index just above them.
  for (genvar m = 1; m <= BANK_W; m++) begin : g_mode
    assign lb_cand[m] = BANK_W'(win[m-1:0]);
    assign ix_cand[m] = win[m +: IDX_W];
  end

  logic [BANK_W-1:0] log_bank;
  logic [31:0]       pair_pos;
  logic              unused_pos;

  always_comb begin
    log_bank  = '0;
    set_index = '0;
    for (int m = 1; m <= BANK_W; m++) begin
      if (bank_bits == SHIFT_W'(m)) begin
        log_bank  = lb_cand[m];
        set_index = ix_cand[m];
      end
    end
  end

  // Logical pair ordinal picks which enabled mask bit backs the bank.
  assign pair_pos   = 32'(nth_set_pos(32'(mask), 32'(log_bank >> 1)));
  assign phys_bank  = {pair_pos[BANK_W-2:0], log_bank[0]};
  assign unused_pos = ^pair_pos[31:BANK_W-1];
endmodule

// File: rtl/rdw_word_build.sv
module rdw_word_build #(
  parameter int IDX_W   = 9,
  parameter int LWAY_W  = 4,
  parameter int CORE_W  = 3,
  parameter int L1WAY_W = 2,
  localparam int TAG_W   = IDX_W + LWAY_W,
  localparam int ENTRY_W = 1 + CORE_W + L1WAY_W,
  localparam int DATA_W  = TAG_W + 3
) (
  input  logic [IDX_W-1:0]   set_index,
  input  logic [LWAY_W-1:0]  lway,
  input  logic [CORE_W-1:0]  core,
  input  logic [L1WAY_W-1:0] l1way,
  input  logic               a4,
  output logic [ENTRY_W-1:0] entry,
  output logic [DATA_W-1:0]  data
);

  function automatic logic [TAG_W-1:0] make_tag(input logic [IDX_W-1:0] ix,
                                                input logic [LWAY_W-1:0] w);
    return {ix, w};
  endfunction

  function automatic logic fold_parity(input logic [TAG_W-1:0] t, input logic extra);
    return (^t) ^ extra;
  endfunction

  logic [TAG_W-1:0] tag;
  logic             par;

  assign tag   = make_tag(set_index, lway);
  assign par   = fold_parity(tag, a4);
  assign data  = {1'b1, par, a4, tag};
  assign entry = {a4, core, l1way};
endmodule

// File: rtl/rdw_entry_writer.sv
module rdw_entry_writer #(
  parameter int ADDR_W    = 40,
  parameter int PAIRS     = 4,
  parameter int LINE_LSB  = 6,
  parameter int IDX_W     = 9,
  parameter int LWAY_W    = 4,
  parameter int CORE_W    = 3,
  parameter int L1WAY_W   = 2,
  parameter int ROW_BIT   = 5,
  parameter int PANEL_LSB = 9,
  parameter int PANELS    = 4,
  localparam int BANK_W   = $clog2(2 * PAIRS),
  localparam int SHIFT_W  = $clog2(BANK_W + 1),
  localparam int WIN_W    = BANK_W + IDX_W,
  localparam int WIN_HI   = LINE_LSB + WIN_W - 1,
  localparam int PANEL_W  = $clog2(PANELS),
  localparam int ENTRY_W  = 1 + CORE_W + L1WAY_W,
  localparam int DATA_W   = IDX_W + LWAY_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LWAY_W-1:0]  req_lway,
  input  logic [CORE_W-1:0]  req_core,
  input  logic [L1WAY_W-1:0] req_l1way,
  input  logic               req_a4,
  input  logic [PAIRS-1:0]   bank_mask,
  output logic               wr_en,
  output logic [BANK_W-1:0]  wr_bank,
  output logic               wr_row,
  output logic [PANELS-1:0]  wr_panel,
  output logic [ENTRY_W-1:0] wr_entry,
  output logic [DATA_W-1:0]  wr_data,
  output logic               cfg_fault
);

  // Only bits at and above the line boundary feed bank and index: this is
  // the 64-byte alignment of the request address.
  logic [WIN_W-1:0]   win;
  logic               unused_addr;
  assign win         = req_addr[LINE_LSB +: WIN_W];
  assign unused_addr = ^{req_addr[ADDR_W-1:WIN_HI+1], req_addr[ROW_BIT-1:0]};

  // Named internal events, also visible to the bound checker.
  logic               mode_ok;
  logic [SHIFT_W-1:0] bank_bits;
  logic [BANK_W-1:0]  phys_bank;
  logic [IDX_W-1:0]   set_index;
  logic [ENTRY_W-1:0] entry_c;
  logic [DATA_W-1:0]  data_c;
  logic [PANELS-1:0]  panel_c;
  logic               do_write;
  logic               do_fault;

  rdw_mode_decode #(.PAIRS(PAIRS), .SHIFT_W(SHIFT_W)) i_mode (
    .mask      (bank_mask),
    .mode_ok   (mode_ok),
    .bank_bits (bank_bits)
  );

  rdw_bank_map #(.PAIRS(PAIRS), .BANK_W(BANK_W), .SHIFT_W(SHIFT_W), .IDX_W(IDX_W)) i_map (
    .win       (win),
    .mask      (bank_mask),
    .bank_bits (bank_bits),
    .phys_bank (phys_bank),
    .set_index (set_index)
  );

  rdw_word_build #(.IDX_W(IDX_W), .LWAY_W(LWAY_W), .CORE_W(CORE_W), .L1WAY_W(L1WAY_W)) i_word (
    .set_index (set_index),
    .lway      (req_lway),
    .core      (req_core),
    .l1way     (req_l1way),
    .a4        (req_a4),
    .entry     (entry_c),
    .data      (data_c)
  );

  assign panel_c  = PANELS'(1) << req_addr[PANEL_LSB +: PANEL_W];
  assign do_write = req_valid && mode_ok;
  assign do_fault = req_valid && !mode_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      cfg_fault <= 1'b0;
      wr_bank   <= '0;
      wr_row    <= 1'b0;
      wr_panel  <= '0;
      wr_entry  <= '0;
      wr_data   <= '0;
    end else begin
      wr_en     <= do_write;
      cfg_fault <= do_fault;
      if (do_write) begin
        wr_bank  <= phys_bank;
        wr_row   <= req_addr[ROW_BIT];
        wr_panel <= panel_c;
        wr_entry <= entry_c;
        wr_data  <= data_c;
      end
    end
  end
endmodule

// File: rtl/rdw_entry_writer_chk.sv
module rdw_entry_writer_chk #(
  parameter int PAIRS   = 4,
  parameter int BANK_W  = 3,
  parameter int CORE_W  = 3,
  parameter int L1WAY_W = 2,
  parameter int PANELS  = 4,
  parameter int ENTRY_W = 6,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_a4,
  input logic [CORE_W-1:0]  req_core,
  input logic [L1WAY_W-1:0] req_l1way,
  input logic [PAIRS-1:0]   bank_mask,
  input logic               mode_ok,
  input logic [BANK_W-1:0]  phys_bank,
  input logic               wr_en,
  input logic [PANELS-1:0]  wr_panel,
  input logic [ENTRY_W-1:0] wr_entry,
  input logic [DATA_W-1:0]  wr_data,
  input logic               cfg_fault
);
  int unsigned mask_pop;
  logic        mask_legal;
  assign mask_pop   = $countones(bank_mask);
  assign mask_legal = (mask_pop != 0) && ((mask_pop & (mask_pop - 1)) == 0);

  assert_strobe_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || cfg_fault) |-> $past(req_valid));

  assert_idle_is_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!wr_en && !cfg_fault));

  assert_legal_mask_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mask_legal) |=> (wr_en && !cfg_fault));

  assert_bad_mask_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mask_legal) |=> (cfg_fault && !wr_en));

  assert_bank_in_enabled_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_ok) |-> bank_mask[phys_bank[BANK_W-1:1]]);

  assert_entry_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_entry == $past({req_a4, req_core, req_l1way})));

  assert_panel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_panel) == 1));

  assert_layout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[DATA_W-1] && (wr_data[DATA_W-3] == wr_entry[ENTRY_W-1])));

  assert_even_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(^wr_data[DATA_W-2:0]));
endmodule

bind rdw_entry_writer rdw_entry_writer_chk #(
  .PAIRS(PAIRS), .BANK_W(BANK_W), .CORE_W(CORE_W), .L1WAY_W(L1WAY_W),
  .PANELS(PANELS), .ENTRY_W(ENTRY_W), .DATA_W(DATA_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_a4    (req_a4),
  .req_core  (req_core),
  .req_l1way (req_l1way),
  .bank_mask (bank_mask),
  .mode_ok   (mode_ok),
  .phys_bank (phys_bank),
  .wr_en     (wr_en),
  .wr_panel  (wr_panel),
  .wr_entry  (wr_entry),
  .wr_data   (wr_data),
  .cfg_fault (cfg_fault)
);

// File: tb/test_rdw_entry_writer.sv
module test_rdw_entry_writer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam int SWEEP = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [39:0] req_addr = '0;
  logic [3:0]  req_lway = '0;
  logic [2:0]  req_core = '0;
  logic [1:0]  req_l1way = '0;
  logic        req_a4 = 1'b0;
  logic [3:0]  bank_mask = 4'hF;
  logic        wr_en;
  logic [2:0]  wr_bank;
  logic        wr_row;
  logic [3:0]  wr_panel;
  logic [5:0]  wr_entry;
  logic [15:0] wr_data;
  logic        cfg_fault;

  int nchk = 0;
  int nfail = 0;
  logic finished = 1'b0;

  rdw_entry_writer i_rdw_entry_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_lway(req_lway), .req_core(req_core), .req_l1way(req_l1way),
    .req_a4(req_a4), .bank_mask(bank_mask), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_row(wr_row), .wr_panel(wr_panel), .wr_entry(wr_entry),
    .wr_data(wr_data), .cfg_fault(cfg_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // stimulus {addr40, lway4, core3, l1way2, a4, mask4}; expected {fault, bank3, row, panel4, entry6, data16}
  localparam logic [53:0] STIM [NVEC] = '{
    {40'h00_0002_0B40, 4'hA, 3'd3, 2'd2, 1'b1, 4'b1111},
    {40'h00_0002_0B40, 4'h3, 3'd0, 2'd0, 1'b0, 4'b0110},
    {40'hFF_1234_5678, 4'h0, 3'd7, 2'd1, 1'b0, 4'b1000},
    {40'hFF_1234_5678, 4'hF, 3'd5, 2'd3, 1'b1, 4'b1111},
    {40'h00_0000_00C0, 4'h1, 3'd2, 2'd0, 1'b0, 4'b0101},
    {40'h00_0002_0B40, 4'hA, 3'd3, 2'd2, 1'b1, 4'b0111},
    {40'h00_0002_0B40, 4'hA, 3'd3, 2'd2, 1'b1, 4'b0000}
  };
  localparam logic [30:0] EXPV [NVEC] = '{
    {1'b0, 3'd5, 1'b0, 4'b0010, 6'h2E, 16'hB05A},
    {1'b0, 3'd3, 1'b0, 4'b0010, 6'h00, 16'hC0B3},
    {1'b0, 3'd7, 1'b1, 4'b1000, 6'h1D, 16'h8AC0},
    {1'b0, 3'd1, 1'b1, 4'b1000, 6'h37, 16'hE2BF},
    {1'b0, 3'd5, 1'b0, 4'b0001, 6'h08, 16'hC001},
    {1'b1, 30'd0},
    {1'b1, 30'd0}
  };

  // Independent model written with arithmetic on the requirement text.
  function automatic logic [30:0] model(input longint addr, input int lway, input int core,
                                        input int l1w, input int a4, input int mask);
    int pop, nb, shift, lb, idx, ord, seen, p, tag, ones, par, data, entry, row, panel;
    pop = 0;
    for (int k = 0; k < 4; k++) if ((mask >> k) % 2 == 1) pop++;
    if (!(pop == 1 || pop == 2 || pop == 4)) return {1'b1, 30'd0};
    nb    = 2 * pop;
    shift = (nb == 8) ? 3 : (nb == 4) ? 2 : 1;
    lb    = int'((addr / 64) % nb);
    idx   = int'((addr / (64 * nb)) % 512);
    ord   = lb / 2;
    seen  = 0;
    p     = 0;
    for (int k = 0; k < 4; k++) begin
      if ((mask >> k) % 2 == 1) begin
        if (seen == ord) p = k;
        seen++;
      end
    end
    tag  = idx * 16 + lway;
    ones = 0;
    for (int k = 0; k < 13; k++) ones += (tag >> k) % 2;
    par   = (ones + a4) % 2;
    data  = 32768 + par * 16384 + a4 * 8192 + tag;
    entry = a4 * 32 + core * 4 + l1w;
    row   = int'((addr / 32) % 2);
    panel = 1 << int'((addr / 512) % 4);
    if (shift == 0) return '0;
    return {1'b0, 3'(2 * p + lb % 2), 1'(row), 4'(panel), 6'(entry), 16'(data)};
  endfunction

  task automatic drive(input logic [53:0] s);
    {req_addr, req_lway, req_core, req_l1way, req_a4, bank_mask} = s;
    req_valid = 1'b1;
  endtask

  task automatic compare(input string tag, input logic [30:0] exp);
    logic [30:0] got;
    got = {cfg_fault, wr_bank, wr_row, wr_panel, wr_entry, wr_data};
    nchk++;
    if (exp[30]) begin
      if (!(cfg_fault && !wr_en)) begin
        nfail++;
        $display("FAIL %s: {wr_en,cfg_fault} actual %b expected 01", tag, {wr_en, cfg_fault});
      end
    end else if (!wr_en || got != exp) begin
      nfail++;
      $display("FAIL %s: wr_en=%b actual %h expected %h", tag, wr_en, got, exp);
    end
  endtask

  task automatic expect_quiet(input string tag);
    nchk++;
    if (wr_en || cfg_fault) begin
      nfail++;
      $display("FAIL %s: {wr_en,cfg_fault} actual %b expected 00", tag, {wr_en, cfg_fault});
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [63:0] lf;
    logic [53:0] s;
    // R1: reset state
    repeat (3) @(negedge clk);
    nchk++;
    if ({wr_en, cfg_fault, wr_bank, wr_row, wr_panel, wr_entry, wr_data} != '0) begin
      nfail++;
      $display("FAIL R1 reset: actual %h expected 0",
               {wr_en, cfg_fault, wr_bank, wr_row, wr_panel, wr_entry, wr_data});
    end
    rst_n = 1'b1;
    @(negedge clk);
    expect_quiet("R1 after release");

    // Table of vectors
    for (int v = 0; v < NVEC; v++) begin
      drive(STIM[v]);
      @(negedge clk);
      req_valid = 1'b0;
      compare($sformatf("R3/R4/R5/R6/R7/R8/R9/R10 vector %0d", v), EXPV[v]);
      @(negedge clk);
      expect_quiet($sformatf("R2 single pulse vector %0d", v));
    end

    // R11: low offset bits and high bits do not matter
    s = STIM[0];
    s[53:14] = s[53:14] | 40'hAB_0000_001F;
    s[53:14] = s[53:14] & ~40'h00_0000_0020;
    drive(s);
    @(negedge clk);
    req_valid = 1'b0;
    compare("R11 offset bits ignored", EXPV[0]);

    // R2: back-to-back requests, one strobe each
    drive(STIM[0]);
    @(negedge clk);
    compare("R2 back-to-back first", EXPV[0]);
    drive(STIM[3]);
    @(negedge clk);
    compare("R2 back-to-back second", EXPV[3]);
    drive(STIM[5]);
    @(negedge clk);
    req_valid = 1'b0;
    compare("R3 fault after writes", EXPV[5]);
    @(negedge clk);
    expect_quiet("R2 idle after burst");

    // R2: illegal mask with no request raises nothing
    bank_mask = 4'b0111;
    repeat (2) @(negedge clk);
    expect_quiet("R2 bad mask without request");

    // R3..R10 sweep against the model
    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < SWEEP; n++) begin
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 7);
      lf = lf ^ (lf << 17);
      s = {lf[39:0], lf[43:40], lf[46:44], lf[48:47], lf[49], lf[53:50]};
      if (n % 3 != 0) s[3:0] = (n % 3 == 1) ? 4'b1111 : {lf[55], ~lf[55], lf[55], ~lf[55]};
      drive(s);
      @(negedge clk);
      req_valid = (n % 5 == 0);
      compare($sformatf("R3/R4/R5/R6/R9/R10 sweep %0d", n),
              model(longint'(s[53:14]), int'(s[13:10]), int'(s[9:7]), int'(s[6:5]),
                    int'(s[4]), int'(s[3:0])));
      req_valid = 1'b0;
    end
    @(negedge clk);
    expect_quiet("R2 end idle");
    finish_run();
  end
endmodule